// File: doc/BRIEF.md
# Multi-Queue Message Mailbox

The block is a word-addressed mailbox that carries fixed-size messages between processors through a set of hardware FIFO queues. Every message is sixteen 32-bit words. A producer writes the words of a message one at a time into a queue's data window, and the message enters the queue when its final word is written. A consumer reads the head message word by word, and that message leaves the queue when its final word is read. No separate "send" or "acknowledge" register is needed.

Each queue can be reached through several proxy windows, one per processor, and all of them lead to the same storage. A status page reports how many messages each queue holds, together with a sticky flag for a commit that found its queue full. Each queue drives one interrupt line, which stays high while the queue is not empty. The number of queues, the queue depth and the number of proxy windows are parameters. The default build is small, and a full-size build scales the same structure up.

Top module: `msg_mailbox`

## Requirements
- R1: After reset every queue holds zero messages, every irq bit is 0, bus_rdata is 0 and every overflow flag is clear.
- R2: The data word for proxy p, queue q and register index r sits at byte address 0x10000·p + 0x80·q + 4·r. Indices 16 to 31 carry message words 0 to 15. Every proxy below NUM_PROXY reaches the same queue storage.
- R3: A write to register index 31 of a queue that is not full appends the assembled message, so the count rises by one.
- R4: A read returns the addressed word of the head message on bus_rdata in the cycle after the request. A read of index 31 of a non-empty queue removes the head message.
- R5: Messages leave a queue in the order in which they were committed.
- R6: The status word of queue q is at byte address 0xF0000 + 4·q. It gives the message count in bits 23:12 and the overflow flag in bit 0, and all other bits read as 0.
- R7: A commit to a full queue is dropped and leaves the count unchanged. It also sets the sticky overflow flag, which stays set until a write to that queue's status word with bit 0 set clears it.
- R8: A read of any data index of an empty queue returns 0. A read of index 31 of an empty queue leaves the count unchanged.
- R9: irq[q] is 1 exactly while queue q holds at least one message, so it falls after the read that removes the only pending message.
- R10: Accesses with a non-zero byte offset, a register index below 16, a queue index of NUM_Q or above, or a proxy index at or above NUM_PROXY (other than the status page) change nothing, and reads of them return 0.
- R11: Traffic on one queue never changes the count, contents or overflow flag of another queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one word per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 20 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq | output | NUM_Q | Per-queue not-empty interrupt |

## Verification
The assertions run on every cycle and check the following:
- each queue's occupancy stays within its depth and moves by exactly one on a commit or a pop;
- a commit to a full queue keeps the count and raises the overflow flag;
- a pop of an empty queue changes nothing;
- an interrupt only falls after a pop;
- a read of an empty queue returns zero.

Only the bench scenarios can show the data path. This covers:
- that words come back in commit order and through any proxy window;
- that the status word packs the count and the flag at the right bit positions;
- that the overflow flag clears only on request;
- that stray addresses leave every queue untouched.

// File: rtl/msgq_pkg.sv
package msgq_pkg;
    localparam int WORD_W      = 32;
    localparam int MSG_WORDS   = 16;
    localparam int WIDX_W      = 4;
    localparam int ADDR_W      = 20;
    localparam int CNT_FIELD_W = 12;
    localparam logic [3:0] STATUS_PAGE = 4'hF;

    function automatic logic [WORD_W-1:0] pack_status(
        input logic [CNT_FIELD_W-1:0] cnt,
        input logic                   ovf
    );
        return {8'd0, cnt, 11'd0, ovf};
    endfunction
endpackage

// File: rtl/msgq_decode.sv
module msgq_decode
    import msgq_pkg::*;
#(
    parameter int NUM_Q     = 4,
    parameter int NUM_PROXY = 2,
    localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_data,
    output logic              hit_status,
    output logic [QW-1:0]     qsel,
    output logic [WIDX_W-1:0] word
);
    localparam logic [3:0]  PROXY_LIM = 4'(NUM_PROXY);
    localparam logic [8:0]  QLIM_D    = 9'(NUM_Q);
    localparam logic [13:0] QLIM_S    = 14'(NUM_Q);

    logic       aligned;
    logic [3:0] proxy;

    always_comb begin
        aligned    = (addr[1:0] == 2'b00);
        proxy      = addr[19:16];
        hit_data   = aligned && (proxy < PROXY_LIM) && (addr[15:7] < QLIM_D) && addr[6];
        hit_status = aligned && (proxy == STATUS_PAGE) && (addr[15:2] < QLIM_S);
        qsel       = hit_status ? addr[2 +: QW] : addr[7 +: QW];
        word       = addr[5:2];
    end
endmodule

// File: rtl/msgq_queue.sv
module msgq_queue
    import msgq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WIDX_W-1:0] wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              commit,
    input  logic [WIDX_W-1:0] rd_word,
    input  logic              pop,
    input  logic              ovf_clr,
    output logic [WORD_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count,
    output logic              ovf
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } qstate_t;

    qstate_t st_d, st_q;
    logic    full, empty, do_push, do_pop;

    logic [WORD_W-1:0] mem [DEPTH*MSG_WORDS];

    always_comb begin
        st_d    = st_q;
        full    = (st_q.cnt == FULL_CNT);
        empty   = (st_q.cnt == '0);
        do_push = commit && !full;
        do_pop  = pop && !empty;
        if (do_push) st_d.tail = st_q.tail + 1'b1;
        if (do_pop)  st_d.head = st_q.head + 1'b1;
        st_d.cnt = st_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        if (ovf_clr)             st_d.ovf = 1'b0;
        else if (commit && full) st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en && !full) mem[{st_q.tail, wr_word}] <= wr_data;
    end

    assign rd_data = empty ? '0 : mem[{st_q.head, rd_word}];
    assign count   = st_q.cnt;
    assign ovf     = st_q.ovf;

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    assert_push_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !pop && count != FULL_CNT) |=> count == $past(count) + 1'b1);
    assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !pop && !ovf_clr && count == FULL_CNT) |=> (ovf && $stable(count)));
    assert_pop_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !commit && count != '0) |=> count == $past(count) - 1'b1);
    assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !commit && count == '0) |=> $stable(count));
endmodule

// File: rtl/msg_mailbox.sv
module msg_mailbox
    import msgq_pkg::*;
#(
    parameter int NUM_Q     = 4,
    parameter int DEPTH     = 4,
    parameter int NUM_PROXY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [NUM_Q-1:0]  irq
);
    localparam int QW    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
    } top_state_t;

    top_state_t st_d, st_q;

    logic              hit_data, hit_status;
    logic [QW-1:0]     qsel;
    logic [WIDX_W-1:0] word;

    logic [NUM_Q-1:0]  q_wr, q_commit, q_pop, q_clr, q_ovf;
    logic [WORD_W-1:0] q_rdata [NUM_Q];
    logic [CNT_W-1:0]  q_cnt   [NUM_Q];

    msgq_decode #(.NUM_Q(NUM_Q), .NUM_PROXY(NUM_PROXY)) u_dec (
        .addr(bus_addr), .hit_data(hit_data), .hit_status(hit_status),
        .qsel(qsel), .word(word)
    );

    for (genvar i = 0; i < NUM_Q; i++) begin : g_q
        logic sel;
        assign sel         = bus_req && (qsel == QW'(i));
        assign q_wr[i]     = sel && bus_we && hit_data;
        assign q_commit[i] = q_wr[i] && (word == 4'hF);
        assign q_pop[i]    = sel && !bus_we && hit_data && (word == 4'hF);
        assign q_clr[i]    = sel && bus_we && hit_status && bus_wdata[0];
        assign irq[i]      = (q_cnt[i] != '0);

        msgq_queue #(.DEPTH(DEPTH)) u_queue (
            .clk(clk), .rst_n(rst_n),
            .wr_en(q_wr[i]), .wr_word(word), .wr_data(bus_wdata),
            .commit(q_commit[i]), .rd_word(word), .pop(q_pop[i]),
            .ovf_clr(q_clr[i]), .rd_data(q_rdata[i]),
            .count(q_cnt[i]), .ovf(q_ovf[i])
        );

        assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq[i]) |-> $past(q_pop[i]));
    end

    always_comb begin
        st_d = st_q;
        if (bus_req && !bus_we) begin
            if (hit_data)
                st_d.rdata = q_rdata[qsel];
            else if (hit_status)
                st_d.rdata = pack_status(CNT_FIELD_W'(q_cnt[qsel]), q_ovf[qsel]);
            else
                st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

    assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && hit_data && q_cnt[qsel] == '0) |=> bus_rdata == '0);
    assert_stray_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && !hit_data && !hit_status) |=> bus_rdata == '0);
endmodule

// File: tb/sim_msg_mailbox.sv
module sim_msg_mailbox;
    localparam int NQ = 4;
    localparam int DEPTH = 4;
    localparam int NP = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NQ-1:0] irq;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // reference model
    logic [511:0] mq [NQ][$];
    logic [511:0] stage [NQ];
    logic         movf [NQ];

    always #5 clk = ~clk;

    msg_mailbox #(.NUM_Q(NQ), .DEPTH(DEPTH), .NUM_PROXY(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [19:0] daddr(int p, int q, int r);
        return 20'(p * 32'h10000 + q * 32'h80 + r * 4);
    endfunction

    function automatic logic [19:0] saddr(int q);
        return 20'(32'hF0000 + q * 4);
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_op(bit we, logic [19:0] a, logic [31:0] wd, output logic [31:0] exp);
        int p, qq, r, w;
        p = int'(a[19:16]);
        qq = int'(a[15:7]);
        r = int'(a[6:2]);
        exp = '0;
        if (a[1:0] == 2'b00 && p < NP && qq < NQ && r >= 16) begin
            w = r - 16;
            if (we) begin
                if (mq[qq].size() < DEPTH) stage[qq][w*32 +: 32] = wd;
                if (w == 15) begin
                    if (mq[qq].size() == DEPTH) movf[qq] = 1'b1;
                    else mq[qq].push_back(stage[qq]);
                end
            end else if (mq[qq].size() > 0) begin
                exp = mq[qq][0][w*32 +: 32];
                if (w == 15) void'(mq[qq].pop_front());
            end
        end else if (a[1:0] == 2'b00 && p == 15 && int'(a[15:2]) < NQ) begin
            qq = int'(a[15:2]);
            if (we) begin
                if (wd[0]) movf[qq] = 1'b0;
            end else begin
                exp = {8'd0, 12'(mq[qq].size()), 11'd0, movf[qq]};
            end
        end
    endtask

    task automatic acc(bit we, logic [19:0] a, logic [31:0] wd, string tag);
        logic [31:0] exp;
        logic [NQ-1:0] mirq;
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0;
        model_op(we, a, wd, exp);
        if (!we) chk(bus_rdata == exp, tag, bus_rdata, exp);
        for (int i = 0; i < NQ; i++) mirq[i] = (mq[i].size() != 0);
        chk(irq == mirq, "R9 irq", 32'(irq), 32'(mirq));
    endtask

    task automatic write_msg(int p, int q, int id);
        for (int r = 16; r < 32; r++)
            acc(1'b1, daddr(p, q, r), {8'(q), 8'(id), 16'(r * 3 + 1)}, "R3 write");
    endtask

    task automatic read_msg(int p, int q);
        for (int r = 16; r < 32; r++)
            acc(1'b0, daddr(p, q, r), '0, "R4 R5 read");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NQ; i++) begin
            stage[i] = '0;
            movf[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(irq == '0, "R1 irq", 32'(irq), 32'd0);
        chk(bus_rdata == '0, "R1 rdata", bus_rdata, 32'd0);
        for (int q = 0; q < NQ; q++) acc(1'b0, saddr(q), '0, "R1 R6 status");

        // R2/R3/R4/R5/R6/R9: two messages through different proxies
        write_msg(0, 0, 1);
        acc(1'b0, saddr(0), '0, "R3 R6 count after commit");
        write_msg(1, 0, 2);
        acc(1'b0, saddr(0), '0, "R6 count two");
        read_msg(1, 0);
        acc(1'b0, saddr(0), '0, "R4 count after pop");
        read_msg(0, 0);
        acc(1'b0, saddr(0), '0, "R9 empty after last pop");

        // R8: empty queue reads
        acc(1'b0, daddr(0, 0, 20), '0, "R8 empty word");
        acc(1'b0, daddr(0, 0, 31), '0, "R8 empty last");
        acc(1'b0, saddr(0), '0, "R8 count unchanged");

        // R7: overflow
        for (int m = 0; m < DEPTH + 1; m++) write_msg(0, 2, 10 + m);
        acc(1'b0, saddr(2), '0, "R7 overflow set");
        acc(1'b1, saddr(2), 32'h0, "R7 no clear");
        acc(1'b0, saddr(2), '0, "R7 still set");
        acc(1'b1, saddr(2), 32'h1, "R7 clear");
        acc(1'b0, saddr(2), '0, "R7 cleared");
        for (int m = 0; m < DEPTH; m++) read_msg(m % NP, 2);
        acc(1'b0, saddr(2), '0, "R5 drained");

        // R10: stray accesses
        acc(1'b1, daddr(0, 1, 5), 32'hDEAD, "R10 low index write");
        acc(1'b1, daddr(0, 1, 15), 32'hDEAD, "R10 low index write");
        acc(1'b1, daddr(0, NQ, 31), 32'hBEEF, "R10 bad queue");
        acc(1'b1, daddr(NP, 1, 31), 32'hBEEF, "R10 bad proxy");
        acc(1'b1, daddr(0, 1, 31) | 20'h1, 32'hBEEF, "R10 unaligned");
        acc(1'b0, daddr(0, 1, 3), '0, "R10 low index read");
        acc(1'b0, daddr(0, NQ, 16), '0, "R10 bad queue read");
        acc(1'b0, saddr(NQ), '0, "R10 bad status read");
        acc(1'b0, saddr(1), '0, "R10 queue untouched");

        // R11: interleaved independent queues
        write_msg(0, 1, 30);
        write_msg(1, 3, 31);
        write_msg(1, 1, 32);
        acc(1'b0, saddr(3), '0, "R11 q3 count");
        read_msg(0, 3);
        acc(1'b0, saddr(1), '0, "R11 q1 count");
        read_msg(1, 1);
        read_msg(0, 1);
        for (int q = 0; q < NQ; q++) acc(1'b0, saddr(q), '0, "R11 final status");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule